// File: doc/BRIEF.md
# BCD Calendar Clock Register File

This block holds a real-time clock's time and date as eight bytes of packed BCD. The bytes are seconds, minutes, hours with two century flags, day of week, day of month, month, year and a free control byte. A one-second tick from an external prescaler advances the time. A byte-wide bus reads and writes the bytes. A pointer is loaded once and then steps forward by one after every read or write, so a whole block can be read or written in consecutive cycles.

A read of any time byte (addresses 0 to 6) opens a hold window of `HOLD_CYCLES` clock cycles. While the window is open, the visible bytes do not change, so a block read returns one consistent snapshot. Ticks that arrive during the window are counted in a small pending counter. When the window closes, they are applied one per cycle, so no time is lost. A stop flag in the seconds byte freezes the time.

Top module: `rtc_regfile`

## Requirements
- R1: Address 0 is seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year and 7 control. All time fields are packed BCD with the tens digit in bits 7-4. Each read or write moves the pointer up by one, and the pointer wraps from 7 to 0.
- R2: Written values are masked so that unused bits read back as 0: minutes bit 7, day-of-week bits 7-3, date bits 7-6 and month bits 7-5. Writing 0xFF therefore reads back as 0x7F, 0x07, 0x3F and 0x1F respectively. Seconds, hours, year and control keep all eight bits.
- R3: After reset the bytes read 00:00:00, day 1, date 01, month 01, year 00, and the control byte reads 0x80 (output-level bit 7 set, frequency-test bit 6 clear).
- R4: Each applied tick adds one second. Seconds wrap 59 to 00 and carry into minutes. Minutes wrap 59 to 00 and carry into hours. Hours (bits 5-0) wrap 23 to 00.
- R5: Day of week steps by one at midnight and wraps from 7 to 1.
- R6: At midnight the date wraps to 01 after the last day of the month. The last day is 30 for months 04, 06, 09 and 11, and 31 for the other months except February. February ends on 29 when the year's decimal value is a multiple of 4 and on 28 otherwise. Month wraps 12 to 01 and carries into the year. Year wraps 99 to 00.
- R7: Hours bit 7 is the century enable and hours bit 6 is the century flag. When the year wraps from 99 to 00, bit 6 inverts if bit 7 is 1 and is left unchanged otherwise.
- R8: While seconds bit 7 (stop) is 1, ticks are discarded and the time stays fixed. After the bit is cleared, the next tick advances the time.
- R9: A read of address 0-6 while no hold is open opens a hold for `HOLD_CYCLES` cycles. Reads made during the hold do not extend it. The visible time does not change during the hold. Ticks received during the hold are applied one per cycle after it closes.
- R10: A read of address 7 does not open a hold, so a tick in the next cycle is applied at once.
- R11: A write to any byte takes effect at the next clock edge, has priority over a tick applied in the same cycle, and discards all pending ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| secTick | input | 1 | One-cycle pulse, once per second |
| ptrLoad | input | 1 | Loads the byte pointer from ptrIn |
| ptrIn | input | 3 | New pointer value |
| rdEn | input | 1 | Reads the byte at the pointer, then increments the pointer |
| wrEn | input | 1 | Writes wrData at the pointer, then increments the pointer |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Byte at the current pointer (combinational) |

## Verification
The bench builds the block with `HOLD_CYCLES` = 8 and `PEND_W` = 4. With a short window, each tick can be followed by a full seven-byte read and a wait for the window to close, so more than a thousand consecutive seconds can be checked against an arithmetic model across a midnight, year and century rollover. The short window also lets the bench place ticks inside a hold and see exactly when they appear. Every month's last day is swept for a non-leap year, a leap year and year 00, which covers all the month lengths and the February rule.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_SEC  = 3'd0;
  localparam logic [ADDR_W-1:0] A_MIN  = 3'd1;
  localparam logic [ADDR_W-1:0] A_HR   = 3'd2;
  localparam logic [ADDR_W-1:0] A_DOW  = 3'd3;
  localparam logic [ADDR_W-1:0] A_DATE = 3'd4;
  localparam logic [ADDR_W-1:0] A_MON  = 3'd5;
  localparam logic [ADDR_W-1:0] A_YR   = 3'd6;
  localparam logic [ADDR_W-1:0] A_CTL  = 3'd7;

  localparam logic [BYTE_W-1:0] CTL_RESET = 8'h80;

  typedef struct packed {
    logic              advance;
    logic              write;
    logic [ADDR_W-1:0] sel;
  } rtcStrobe_t;
endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int HOLD_CYCLES = 8192,
  parameter int PEND_W      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic              stopped,
  input  logic              ptrLoad,
  input  logic [ADDR_W-1:0] ptrIn,
  input  logic              rdEn,
  input  logic              wrEn,
  output logic [ADDR_W-1:0] ptr,
  output rtcStrobe_t        strobe
);
  localparam int HOLD_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(HOLD_CYCLES);
  localparam logic [PEND_W-1:0] PEND_ONE  = PEND_W'(1);

  logic [HOLD_W-1:0] holdCnt;
  logic [PEND_W-1:0] pending;
  logic readsClock, holdActive, tickIn;

  assign readsClock = rdEn && !wrEn && (ptr != A_CTL);
  assign holdActive = (holdCnt != '0) || readsClock;
  assign tickIn     = secTick && !stopped;

  always_comb begin
    strobe.write   = wrEn;
    strobe.sel     = ptr;
    strobe.advance = !holdActive && !wrEn && ((pending != '0) || tickIn);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr     <= '0;
      holdCnt <= '0;
      pending <= '0;
    end else begin
      if (ptrLoad)            ptr <= ptrIn;
      else if (rdEn || wrEn)  ptr <= ptr + 1'b1;

      if (readsClock && holdCnt == '0) holdCnt <= HOLD_LOAD;
      else if (holdCnt != '0)          holdCnt <= holdCnt - 1'b1;

      if (wrEn)                               pending <= '0;
      else if (tickIn && !strobe.advance)     pending <= pending + PEND_ONE;
      else if (!tickIn && strobe.advance)     pending <= pending - PEND_ONE;
    end
  end

  // R9
  hold_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (readsClock && holdCnt == '0) |=> !strobe.advance);

  // R9
  hold_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    holdCnt <= HOLD_LOAD);

  // R9
  pend_ovf_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(pending == '1 && tickIn && !strobe.advance && !wrEn));

  // R11
  wr_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (pending == '0));
endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  rtcStrobe_t        strobe,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [ADDR_W-1:0] ptr,
  output logic [BYTE_W-1:0] rdData,
  output logic              stopped
);
  logic [BYTE_W-1:0] secR, minR, hrR, dowR, dateR, monR, yrR, ctlR;
  logic [BYTE_W-1:0] secN, minN, hrN, dowN, dateN, monN, yrN;
  logic [BYTE_W-1:0] secInc, minInc, hrInc, dateInc, monInc, yrInc;
  logic [BYTE_W-1:0] lastDay, yearBin, wrMasked;
  logic secWrap, minWrap, hrWrap, dateWrap, monWrap, yrWrap;
  logic cMin, cHr, cDay, cMon, cYr, cCen, leap;

  function automatic logic [BYTE_W-1:0] bcdNext(input logic [BYTE_W-1:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return v + 8'd1;
  endfunction

  assign stopped = secR[7];

  always_comb begin
    yearBin = ({4'd0, yrR[7:4]} * 8'd10) + {4'd0, yrR[3:0]};
    leap    = (yearBin[1:0] == 2'b00);
    case (monR[4:0])
      5'h02:                      lastDay = leap ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: lastDay = 8'h30;
      default:                    lastDay = 8'h31;
    endcase
  end

  always_comb begin
    secInc  = bcdNext({1'b0, secR[6:0]});
    minInc  = bcdNext({1'b0, minR[6:0]});
    hrInc   = bcdNext({2'b0, hrR[5:0]});
    dateInc = bcdNext({2'b0, dateR[5:0]});
    monInc  = bcdNext({3'b0, monR[4:0]});
    yrInc   = bcdNext(yrR);

    secWrap  = (secR[6:0] == 7'h59);
    minWrap  = (minR[6:0] == 7'h59);
    hrWrap   = (hrR[5:0] == 6'h23);
    dateWrap = (dateR == lastDay);
    monWrap  = (monR == 8'h12);
    yrWrap   = (yrR == 8'h99);

    cMin = secWrap;
    cHr  = cMin && minWrap;
    cDay = cHr && hrWrap;
    cMon = cDay && dateWrap;
    cYr  = cMon && monWrap;
    cCen = cYr && yrWrap && hrR[7];

    secN  = {secR[7], secWrap ? 7'h00 : secInc[6:0]};
    minN  = cMin ? {1'b0, minWrap ? 7'h00 : minInc[6:0]} : minR;
    hrN   = {hrR[7], hrR[6] ^ cCen, cHr ? (hrWrap ? 6'h00 : hrInc[5:0]) : hrR[5:0]};
    dowN  = cDay ? {5'd0, (dowR[2:0] == 3'd7) ? 3'd1 : dowR[2:0] + 3'd1} : dowR;
    dateN = cDay ? {2'b0, dateWrap ? 6'h01 : dateInc[5:0]} : dateR;
    monN  = cMon ? {3'b0, monWrap ? 5'h01 : monInc[4:0]} : monR;
    yrN   = cYr ? (yrWrap ? 8'h00 : yrInc) : yrR;
  end

  always_comb begin
    case (strobe.sel)
      A_MIN:   wrMasked = wrData & 8'h7F;
      A_DOW:   wrMasked = wrData & 8'h07;
      A_DATE:  wrMasked = wrData & 8'h3F;
      A_MON:   wrMasked = wrData & 8'h1F;
      default: wrMasked = wrData;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secR  <= 8'h00; minR <= 8'h00; hrR <= 8'h00; dowR <= 8'h01;
      dateR <= 8'h01; monR <= 8'h01; yrR <= 8'h00; ctlR <= CTL_RESET;
    end else if (strobe.write) begin
      case (strobe.sel)
        A_SEC:   secR  <= wrMasked;
        A_MIN:   minR  <= wrMasked;
        A_HR:    hrR   <= wrMasked;
        A_DOW:   dowR  <= wrMasked;
        A_DATE:  dateR <= wrMasked;
        A_MON:   monR  <= wrMasked;
        A_YR:    yrR   <= wrMasked;
        default: ctlR  <= wrMasked;
      endcase
    end else if (strobe.advance) begin
      secR <= secN; minR <= minN; hrR <= hrN; dowR <= dowN;
      dateR <= dateN; monR <= monN; yrR <= yrN;
    end
  end

  always_comb begin
    case (ptr)
      A_SEC:   rdData = secR;
      A_MIN:   rdData = minR;
      A_HR:    rdData = hrR;
      A_DOW:   rdData = dowR;
      A_DATE:  rdData = dateR;
      A_MON:   rdData = monR;
      A_YR:    rdData = yrR;
      default: rdData = ctlR;
    endcase
  end

  // R2
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (minR[7] == 1'b0) && (dowR[7:3] == 5'd0) && (dateR[7:6] == 2'd0) && (monR[7:5] == 3'd0));

  // R11
  wr_min_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.write && strobe.sel == A_MIN) |=> (minR == {1'b0, $past(wrData[6:0])}));

  // R8
  no_strobe_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.advance && !strobe.write) |=>
      ($stable(secR) && $stable(minR) && $stable(hrR) && $stable(dowR) &&
       $stable(dateR) && $stable(monR) && $stable(yrR)));

  // R7
  century_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !strobe.write && secR[6:0] == 7'h59 && minR == 8'h59 &&
     hrR[5:0] == 6'h23 && dateR == 8'h31 && monR == 8'h12 && yrR == 8'h99) |=>
      (yrR == 8'h00 && hrR[6] == ($past(hrR[6]) ^ $past(hrR[7]))));
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_pkg::*;
#(
  parameter int HOLD_CYCLES = 8192,
  parameter int PEND_W      = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       secTick,
  input  logic       ptrLoad,
  input  logic [2:0] ptrIn,
  input  logic       rdEn,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData
);
  rtcStrobe_t        strobe;
  logic [ADDR_W-1:0] ptr;
  logic              stopped;

  rtc_ctrl #(.HOLD_CYCLES(HOLD_CYCLES), .PEND_W(PEND_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .secTick(secTick), .stopped(stopped),
    .ptrLoad(ptrLoad), .ptrIn(ptrIn), .rdEn(rdEn), .wrEn(wrEn),
    .ptr(ptr), .strobe(strobe)
  );

  rtc_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .ptr(ptr), .rdData(rdData), .stopped(stopped)
  );
endmodule

// File: tb/rtc_regfile_test.sv
module rtc_regfile_test;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic secTick = 1'b0, ptrLoad = 1'b0, rdEn = 1'b0, wrEn = 1'b0;
  logic [2:0] ptrIn = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;

  int total = 0;
  int bad = 0;

  int ms, mm, mh, mdw, mdt, mmo, my;
  bit mce, mcb, mst;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_regfile #(.HOLD_CYCLES(HOLD), .PEND_W(4)) uut (
    .clk(clk), .rstN(rstN), .secTick(secTick), .ptrLoad(ptrLoad), .ptrIn(ptrIn),
    .rdEn(rdEn), .wrEn(wrEn), .wrData(wrData), .rdData(rdData)
  );

  function automatic logic [7:0] bcd(input int n);
    return 8'(((n / 10) * 16) + (n % 10));
  endfunction

  function automatic int mlen(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [55:0] expBytes();
    return {bcd(ms) | (mst ? 8'h80 : 8'h00), bcd(mm),
            bcd(mh) | (mce ? 8'h80 : 8'h00) | (mcb ? 8'h40 : 8'h00),
            bcd(mdw), bcd(mdt), bcd(mmo), bcd(my)};
  endfunction

  task automatic modelTick();
    if (mst) return;
    ms++;
    if (ms == 60) begin
      ms = 0; mm++;
      if (mm == 60) begin
        mm = 0; mh++;
        if (mh == 24) begin
          mh = 0;
          mdw = (mdw == 7) ? 1 : mdw + 1;
          if (mdt == mlen(mmo, my)) begin
            mdt = 1;
            if (mmo == 12) begin
              mmo = 1;
              if (my == 99) begin my = 0; if (mce) mcb = ~mcb; end
              else my++;
            end else mmo++;
          end else mdt++;
        end
      end
    end
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic loadPtr(input logic [2:0] a);
    ptrLoad = 1'b1; ptrIn = a;
    @(negedge clk);
    ptrLoad = 1'b0;
  endtask

  task automatic writeByte(input logic [7:0] d);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readByte(output logic [7:0] d);
    rdEn = 1'b1;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic tickOnce();
    secTick = 1'b1;
    @(negedge clk);
    secTick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic readAll(output logic [55:0] got);
    logic [7:0] b;
    loadPtr(3'd0);
    for (int i = 0; i < 7; i++) begin
      readByte(b);
      got = {got[47:0], b};
    end
  endtask

  task automatic checkTime(input string req);
    logic [55:0] got;
    readAll(got);
    check(req, {8'h0, got}, {8'h0, expBytes()});
    idle(HOLD + 2);
  endtask

  task automatic setTime(input int s, input int m, input int h, input int dw,
                         input int dt, input int mo, input int y,
                         input bit ce, input bit cb, input bit st);
    logic [55:0] e;
    ms = s; mm = m; mh = h; mdw = dw; mdt = dt; mmo = mo; my = y;
    mce = ce; mcb = cb; mst = st;
    e = expBytes();
    loadPtr(3'd0);
    for (int i = 6; i >= 0; i--) writeByte(e[i*8 +: 8]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] b, b2;
    logic [55:0] snap;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R3 reset state
    readAll(snap);
    check("R3", {8'h0, snap}, {8'h0, 56'h00_00_00_01_01_01_00});
    idle(HOLD + 2);
    loadPtr(3'd7); readByte(b);
    check("R3 ctl", {56'h0, b}, {56'h0, 8'h80});

    // R1 control write, pointer wraps 7 -> 0
    loadPtr(3'd7); writeByte(8'h55); writeByte(8'h12);
    loadPtr(3'd7); readByte(b); readByte(b2);
    check("R1 ctl", {56'h0, b}, {56'h0, 8'h55});
    check("R1 wrap", {56'h0, b2}, {56'h0, 8'h12});
    idle(HOLD + 2);

    // R2 masking of unused bits
    loadPtr(3'd1);
    for (int i = 0; i < 5; i++) writeByte(8'hFF);
    loadPtr(3'd1); readByte(b); check("R2 min", {56'h0, b}, {56'h0, 8'h7F});
    readByte(b); check("R2 hr", {56'h0, b}, {56'h0, 8'hFF});
    readByte(b); check("R2 dow", {56'h0, b}, {56'h0, 8'h07});
    readByte(b); check("R2 date", {56'h0, b}, {56'h0, 8'h3F});
    readByte(b); check("R2 mon", {56'h0, b}, {56'h0, 8'h1F});
    idle(HOLD + 2);

    // R4 R5 R6 R7 long run across midnight, year and century
    setTime(0, 45, 23, 7, 31, 12, 99, 1'b1, 1'b0, 1'b0);
    checkTime("R1 set");
    for (int i = 0; i < 1000; i++) begin
      tickOnce(); modelTick();
      checkTime("R4");
    end
    check("R5 dow", 64'(mdw), 64'd1);
    check("R7 cen", 64'(mcb), 64'd1);

    // R6 month-end sweep for three years
    for (int yi = 0; yi < 3; yi++) begin
      for (int mo = 1; mo <= 12; mo++) begin
        int y;
        y = (yi == 0) ? 23 : ((yi == 1) ? 24 : 0);
        setTime(59, 59, 23, 3, mlen(mo, y), mo, y, 1'b0, 1'b0, 1'b0);
        tickOnce(); modelTick();
        checkTime("R6");
      end
    end
    setTime(59, 59, 23, 6, 28, 2, 24, 1'b0, 1'b0, 1'b0);
    tickOnce(); modelTick();
    checkTime("R6 leap");
    check("R6 feb29", 64'(mdt), 64'd29);

    // R7 century flag held when enable is clear
    setTime(59, 59, 23, 2, 31, 12, 99, 1'b0, 1'b1, 1'b0);
    tickOnce(); modelTick();
    checkTime("R7 noflip");

    // R8 stop bit
    setTime(10, 5, 4, 2, 3, 4, 5, 1'b0, 1'b0, 1'b1);
    tickOnce(); tickOnce(); tickOnce();
    checkTime("R8 frozen");
    loadPtr(3'd0); writeByte(bcd(10)); mst = 1'b0;
    tickOnce(); modelTick();
    checkTime("R8 resume");

    // R9 hold defers ticks without losing them
    setTime(20, 30, 12, 4, 15, 6, 40, 1'b0, 1'b0, 1'b0);
    loadPtr(3'd0); readByte(b);
    tickOnce(); tickOnce();
    loadPtr(3'd0); readByte(b);
    check("R9 held", {56'h0, b}, {56'h0, 8'h20});
    modelTick(); modelTick();
    idle(HOLD + 4);
    checkTime("R9 applied");

    // R10 control read opens no hold
    loadPtr(3'd7); readByte(b);
    tickOnce(); modelTick();
    loadPtr(3'd0); readByte(b);
    check("R10", {56'h0, b}, {56'h0, bcd(ms)});
    idle(HOLD + 2);

    // R11 write discards pending ticks
    loadPtr(3'd0); readByte(b);
    tickOnce(); tickOnce();
    loadPtr(3'd0); writeByte(8'h30); ms = 30;
    idle(HOLD + 4);
    checkTime("R11");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule